// File: doc/BRIEF.md
# Sub-cycle dithered PWM generator

This block drives a single PWM pin from an 8-bit duty word. One full PWM period is 256 system clocks, and the average duty over that period is the duty word divided by 256. The block raises the switching rate by splitting each period into shorter modulation sub-cycles that repeat. A format input chooses either two sub-cycles of 128 clocks or four sub-cycles of 64 clocks.

The duty word is split into two parts. The upper part is a base high time that every sub-cycle receives. The lower part is a count of sub-cycles, taken from the first one, that each receive one extra high clock. The sum over a period therefore equals the full duty word, while the pin switches two or four times as often as a plain comparator would.

The duty word and the format are captured only at the start of a period. An enable input stops the block: the pin goes low and timing restarts from sub-cycle 0.

Top module: `pwm_dither_gen`

## Requirements
- R1: While `rst` is high, `pwm_o` is 0, and the first period after reset and enable starts at sub-cycle 0.
- R2: A period is 256 clocks long, and the pin is high for exactly `duty_i` clocks in it.
- R3: With `mode_i` = 0, a period holds two 128-clock sub-cycles. The base high time is `duty_i[7:1]` and the extra count is `duty_i[0]`.
- R4: With `mode_i` = 1, a period holds four 64-clock sub-cycles. The base high time is `duty_i[7:2]` and the extra count is `duty_i[1:0]`.
- R5: Sub-cycle i (counted from 0) is high for base+1 clocks when i is less than the extra count, and for base clocks otherwise. The high run starts at the first clock of the sub-cycle and is followed by low for the rest of it.
- R6: Changes to `duty_i` or `mode_i` during a period have no effect on that period. They take effect from the next period.
- R7: When `en_i` is seen low at an edge, `pwm_o` is 0 after that edge and the period position returns to 0. The edge at which `en_i` is first seen high again arms the timer. The next 256 output clocks then form one complete period that starts with sub-cycle 0.
- R8: A duty word of 0 keeps `pwm_o` low for the whole period.
- R9: A sub-cycle whose high time equals its length is high for every clock of that sub-cycle. Examples are duty 255 in either format, for the sub-cycles with i below the extra count.
- R10: `pwm_o` is registered. The value seen after the edge at period position p is the value computed for position p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing counts its edges |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low holds the pin low and clears timing |
| mode_i | input | 1 | Format: 0 = two 128-clock sub-cycles, 1 = four 64-clock sub-cycles |
| duty_i | input | 8 | Duty word, captured at each period start |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The bench covers extra counts that are odd, even, maximal and zero. A design that gave the extra clocks to the last sub-cycles instead of the first, or that split the duty word at the wrong bit, would shift high time between sub-cycles while keeping the total the same; only the per-sub-cycle counts catch that. Duty 255 checks that a high time equal to the sub-cycle length does not wrap to zero or drop a clock. A duty and format change in the middle of a period catches a design that samples its settings live. A disable in the middle of a period, followed by a fresh period, catches a counter that resumes instead of restarting, or an output that lags the enable.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;
  localparam int unsigned DUTY_W_DEF = 8;

  typedef enum logic {
    FMT_HALVES   = 1'b0,
    FMT_QUARTERS = 1'b1
  } split_fmt_e;
endpackage

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             reload_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      active_o <= 1'b0;
    end else begin
      active_o <= en_i;
      if (!en_i) begin
        cnt_o <= '0;
      end else if (active_o) begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end

  // settings may be taken while idle or on the edge that ends a period
  assign reload_o = !active_o || (cnt_o == CNT_LAST);
endmodule

// File: rtl/pwm_setting_hold.sv
module pwm_setting_hold #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              mode_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              mode_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_o <= '0;
      mode_o <= 1'b0;
    end else if (load_i) begin
      duty_o <= duty_i;
      mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/pwm_subcycle_compare.sv
module pwm_subcycle_compare #(
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned IDX_W  = 1
) (
  input  logic [DUTY_W-1:0] pos_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              high_o
);
  localparam int unsigned OFS_W = DUTY_W - IDX_W;

  logic [IDX_W-1:0] sub_idx;
  logic [OFS_W-1:0] sub_ofs;
  logic [OFS_W-1:0] base_w;
  logic [IDX_W-1:0] extra_n;
  logic [OFS_W:0]   high_len;

  always_comb begin
    sub_idx  = pos_i[DUTY_W-1 -: IDX_W];
    sub_ofs  = pos_i[OFS_W-1:0];
    base_w   = duty_i[DUTY_W-1:IDX_W];
    extra_n  = duty_i[IDX_W-1:0];
    high_len = {1'b0, base_w} + {{OFS_W{1'b0}}, (sub_idx < extra_n)};
    high_o   = {1'b0, sub_ofs} < high_len;
  end
endmodule

// File: rtl/pwm_dither_gen.sv
module pwm_dither_gen
  import pwm_dither_pkg::*;
#(
  parameter int unsigned DUTY_W   = DUTY_W_DEF,
  parameter int unsigned IDX_W_LO = 1,
  parameter int unsigned IDX_W_HI = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam int unsigned N_FMT = 2;

  logic [DUTY_W-1:0] cnt;
  logic              active;
  logic              reload;
  logic [DUTY_W-1:0] duty_q;
  logic              mode_q;
  logic [N_FMT-1:0]  fmt_high;
  split_fmt_e        fmt_sel;
  logic              high_now;

  pwm_cycle_counter #(.CNT_W(DUTY_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .cnt_o    (cnt),
    .active_o (active),
    .reload_o (reload)
  );

  pwm_setting_hold #(.DUTY_W(DUTY_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (reload),
    .duty_i (duty_i),
    .mode_i (mode_i),
    .duty_o (duty_q),
    .mode_o (mode_q)
  );

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int unsigned IW = (g == 0) ? IDX_W_LO : IDX_W_HI;
    pwm_subcycle_compare #(.DUTY_W(DUTY_W), .IDX_W(IW)) u_cmp (
      .pos_i  (cnt),
      .duty_i (duty_q),
      .high_o (fmt_high[g])
    );
  end

  always_comb begin
    fmt_sel  = split_fmt_e'(mode_q);
    high_now = (fmt_sel == FMT_QUARTERS) ? fmt_high[1] : fmt_high[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o <= 1'b0;
    end else begin
      pwm_o <= en_i && active && high_now;
    end
  end
endmodule

// File: rtl/pwm_dither_chk.sv
module pwm_dither_chk #(
  parameter int unsigned DUTY_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              pwm_o,
  input logic [DUTY_W-1:0] cnt,
  input logic              active,
  input logic [DUTY_W-1:0] duty_q,
  input logic              mode_q
);
  localparam logic [DUTY_W-1:0] LAST = {DUTY_W{1'b1}};
  localparam logic [DUTY_W-1:0] Q3   = LAST - (LAST >> 2);

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !pwm_o);

  a_r7_off_low: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pwm_o);

  a_r7_pos_clear: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt == '0));

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (en_i && active && cnt == LAST) |=> (cnt == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != LAST) |=> ($stable(duty_q) && $stable(mode_q)));

  a_r8_zero_low: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0) |=> !pwm_o);

  a_r9_full_high: assert property (@(posedge clk) disable iff (rst)
    (en_i && active && mode_q && duty_q == LAST && cnt < Q3) |=> pwm_o);
endmodule

bind pwm_dither_gen pwm_dither_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en_i   (en_i),
  .pwm_o  (pwm_o),
  .cnt    (cnt),
  .active (active),
  .duty_q (duty_q),
  .mode_q (mode_q)
);

// File: tb/tb_pwm_dither_gen.sv
module tb_pwm_dither_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_LEN = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [7:0] duty_i = 8'd0;
  logic       pwm_o;

  int vectors = 0;
  int fails   = 0;
  bit cmp_on  = 1'b0;
  bit done    = 1'b0;
  string cur_req = "R10";

  // behavioural reference state
  int m_pos = 0, m_duty = 0, m_mode = 0;
  bit m_act = 0, m_exp = 0;

  pwm_dither_gen dut (
    .clk(clk), .rst(rst), .en_i(en_i), .mode_i(mode_i),
    .duty_i(duty_i), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit ref_high(int pos, int duty, int mode);
    int sublen = (mode != 0) ? 64 : 128;
    int groups = PERIOD_LEN / sublen;
    int ht = duty / groups + (((pos / sublen) < (duty % groups)) ? 1 : 0);
    return (pos % sublen) < ht;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_act = 0; m_duty = 0; m_mode = 0; m_exp = 0;
    end else begin
      m_exp = en_i && m_act && ref_high(m_pos, m_duty, m_mode);
      if (!m_act || m_pos == PERIOD_LEN - 1) begin
        m_duty = duty_i; m_mode = mode_i;
      end
      if (!en_i) m_pos = 0;
      else if (m_act) m_pos = (m_pos + 1) % PERIOD_LEN;
      m_act = en_i;
    end
  end

  // per-clock comparison with the model (R10 timing, R5 shape)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      vectors++;
      if (pwm_o !== m_exp) begin
        fails++;
        $display("FAIL %s: per-clock pwm_o=%0b expected %0b", cur_req, pwm_o, m_exp);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fresh(input int d, input int m);
    @(negedge clk);
    en_i = 1'b0; duty_i = 8'(d); mode_i = m[0];
    @(negedge clk);
    @(negedge clk);
    en_i = 1'b1;
    @(negedge clk); // arming edge done; next samples are positions 0..255
  endtask

  // samples one period; expected per-sub counts from d/m; optional mid-period change
  task automatic run_period(input int d, input int m, input int chg_at,
                            input int nd, input int nm, input string req);
    int sublen = (m != 0) ? 64 : 128;
    int nsub   = PERIOD_LEN / sublen;
    int cnt_sub[4];
    int total  = 0;
    bit shape_ok = 1'b1;
    cur_req = req;
    foreach (cnt_sub[k]) cnt_sub[k] = 0;
    for (int p = 0; p < PERIOD_LEN; p++) begin
      @(negedge clk);
      #1;
      if (pwm_o) begin
        cnt_sub[p / sublen]++;
        total++;
        if (cnt_sub[p / sublen] != (p % sublen) + 1) shape_ok = 1'b0;
      end
      if (p == chg_at) begin
        duty_i = 8'(nd); mode_i = nm[0];
      end
    end
    check(total == d, "R2", total, d, "high clocks in period");
    for (int i = 0; i < nsub; i++) begin
      int exp_i = d / nsub + ((i < d % nsub) ? 1 : 0);
      check(cnt_sub[i] == exp_i, (m != 0) ? "R4" : "R3", cnt_sub[i], exp_i,
            $sformatf("high clocks in sub-cycle %0d", i));
    end
    check(shape_ok, "R5", shape_ok, 1, "high run starts at sub-cycle start and is contiguous");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(pwm_o == 1'b0, "R1", pwm_o, 0, "pwm_o during reset");
    rst = 1'b0;
    @(negedge clk);
    check(pwm_o == 1'b0, "R1", pwm_o, 0, "pwm_o after reset release");
    cmp_on = 1'b1;

    fresh(8'h81, 0); run_period(8'h81, 0, -1, 0, 0, "R3");
    run_period(8'h81, 0, -1, 0, 0, "R2");
    fresh(8'h80, 0); run_period(8'h80, 0, -1, 0, 0, "R3");
    fresh(8'h87, 1); run_period(8'h87, 1, -1, 0, 0, "R4");
    fresh(8'h02, 1); run_period(8'h02, 1, -1, 0, 0, "R5");
    fresh(8'h00, 1); run_period(8'h00, 1, -1, 0, 0, "R8");
    fresh(8'hFF, 1); run_period(8'hFF, 1, -1, 0, 0, "R9");
    fresh(8'hFF, 0); run_period(8'hFF, 0, -1, 0, 0, "R9");

    // R6: change mid-period, effect only from next period
    fresh(8'h40, 0); run_period(8'h40, 0, 100, 8'hC5, 1, "R6");
    run_period(8'hC5, 1, -1, 0, 0, "R6");

    // R7: disable mid-period, then restart from sub-cycle 0
    fresh(8'hFF, 1);
    cur_req = "R7";
    repeat (10) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    check(pwm_o == 1'b0, "R7", pwm_o, 0, "pwm_o one edge after disable");
    @(negedge clk);
    check(pwm_o == 1'b0, "R7", pwm_o, 0, "pwm_o held low while disabled");
    en_i = 1'b1;
    @(negedge clk);
    check(pwm_o == 1'b0, "R7", pwm_o, 0, "pwm_o on arming edge");
    run_period(8'hFF, 1, -1, 0, 0, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule